// File: doc/BRIEF.md
# Branch and Link Sequencer

This block steers the execute stage of a three-stage fetch/decode/execute core through a taken branch. The PC seen by the execute stage runs 8 bytes ahead of the branch instruction itself. When a branch arrives with its condition met, the block does three things in order:

- In the same cycle it forms the target and sends it to the fetch unit as a redirect. The target is the PC plus the sign-extended 24-bit word displacement, shifted left by two.
- In that cycle it also raises a flush, so the instructions already fetched behind the branch are marked invalid.
- It then runs two refill cycles. When the link form is used, these write the link register twice: first with the captured PC, then with that value minus 4. The link register ends up holding the address of the instruction that follows the branch.

A branch whose condition fails passes through in one cycle. It causes no redirect, no flush and no link write.

Top module: `branchLinkSeq`

## Requirements
- R1: In the cycle where `brIssue` and `condPass` are both high and `busy` is low, `fetchRedirect` is high and `fetchAddr` equals `pcValue + (signext(instr[23:0]) << 2)`, modulo 2^32.
- R2: `flush` is high in the redirect cycle and low in the cycle after it, so each taken branch produces exactly one flush pulse.
- R3: A branch presented with `condPass` low while idle gives no redirect, no flush and no link write, and `busy` stays low in the next cycle.
- R4: When `instr[24]` (the link bit) is 1 on a taken branch, `linkWrEn` is high in the first cycle after the redirect, and `linkWrData` equals the `pcValue` of the redirect cycle.
- R5: On a link branch, `linkWrEn` is also high in the second cycle after the redirect, and `linkWrData` equals the redirect-cycle `pcValue` minus 4.
- R6: When the link bit is 0 on a taken branch, `linkWrEn` stays low in both refill cycles.
- R7: `busy` is high in exactly the two cycles after a redirect and low in the third. While `busy` is high, `brIssue` is ignored: there is no redirect and no flush, and the link values in progress are not disturbed.
- R8: While reset is held and right after it, `busy`, `fetchRedirect`, `flush` and `linkWrEn` are low.
- R9: A displacement with bit 23 set is negative, so the target lies below `pcValue`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brIssue | input | 1 | A branch instruction occupies the execute stage |
| condPass | input | 1 | The branch condition is met |
| instr | input | 32 | Branch instruction word: displacement in bits 23:0, link bit in bit 24 |
| pcValue | input | 32 | PC as read in execute, equal to the branch address plus 8 |
| fetchRedirect | output | 1 | Fetch must take `fetchAddr` as its next address |
| fetchAddr | output | 32 | Branch target |
| flush | output | 1 | Marks the instructions fetched behind the branch as invalid |
| linkWrEn | output | 1 | Write strobe for the link register |
| linkWrData | output | 32 | Value written to the link register |
| busy | output | 1 | A refill cycle is in progress |

## Verification
The sweep covers a set of displacements crossed with several PC values, including one near the top of the address space:

- **Zero displacement:** shows that the adder input is right.
- **Plus and minus one word:** distinguishes the sign extension from zero fill, and the shift by two from no shift.
- **Largest positive and most negative fields:** expose a sign bit taken from the wrong position.
- **PC near the top of the address space:** shows that the target wraps modulo 2^32.

Each combination is run with the link bit both set and clear. This separates the two link writes from the case with no writes, and the PC-relative first write from the corrected value written after it. Condition-failed branches, and branches presented during refill, check that nothing leaks into redirect, flush or the link value in progress.

// File: rtl/blsPkg.sv
package blsPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_ADJUST = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic adjust;
  } dpCtl_t;

endpackage

// File: rtl/blsControl.sv
module blsControl
  import blsPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   brIssue,
  input  logic   condPass,
  input  logic   linkBit,
  output dpCtl_t ctl,
  output logic   redirect,
  output logic   flushOut,
  output logic   linkWrEn,
  output logic   busy
);

  seqState_t state, stateNext;
  logic linkPend;
  logic take;

  assign take = brIssue && condPass && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (take) stateNext = ST_REFILL;
      ST_REFILL: stateNext = ST_ADJUST;
      ST_ADJUST: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      linkPend <= 1'b0;
    end else begin
      state <= stateNext;
      if (take) linkPend <= linkBit;
    end
  end

  always_comb begin
    ctl.capture = take;
    ctl.adjust  = (state == ST_ADJUST);
  end

  assign redirect = take;
  assign flushOut = take;
  assign busy     = (state != ST_IDLE);
  assign linkWrEn = linkPend && busy;

endmodule

// File: rtl/blsDatapath.sv
module blsDatapath
  import blsPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 24,
  parameter int SHIFT    = 2,
  parameter int PC_AHEAD = 8,
  parameter int INSTR_W  = 4 << SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] pcValue,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] linkWrData
);

  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] CORR = ADDR_W'(PC_AHEAD - (INSTR_W / 4));

  logic [OFF_W-1:0]  offField;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] linkReg;

  assign offField  = instr[OFF_W-1:0];
  assign offExt    = {{EXT_W{offField[OFF_W-1]}}, offField};
  assign fetchAddr = pcValue + (offExt << SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) linkReg <= '0;
    else if (ctl.capture) linkReg <= pcValue;
  end

  assign linkWrData = ctl.adjust ? (linkReg - CORR) : linkReg;

endmodule

// File: rtl/branchLinkSeq.sv
module branchLinkSeq
  import blsPkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 24,
  parameter int LINK_BIT = 24,
  parameter int SHIFT    = 2,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brIssue,
  input  logic              condPass,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] pcValue,
  output logic              fetchRedirect,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              flush,
  output logic              linkWrEn,
  output logic [ADDR_W-1:0] linkWrData,
  output logic              busy
);

  dpCtl_t ctl;

  blsControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .brIssue  (brIssue),
    .condPass (condPass),
    .linkBit  (instr[LINK_BIT]),
    .ctl      (ctl),
    .redirect (fetchRedirect),
    .flushOut (flush),
    .linkWrEn (linkWrEn),
    .busy     (busy)
  );

  blsDatapath #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .SHIFT    (SHIFT),
    .PC_AHEAD (PC_AHEAD)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .instr      (instr),
    .pcValue    (pcValue),
    .fetchAddr  (fetchAddr),
    .linkWrData (linkWrData)
  );

endmodule

// File: rtl/branchLinkSeqChk.sv
module branchLinkSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        brIssue,
  input logic        condPass,
  input logic [31:0] instr,
  input logic [31:0] pcValue,
  input logic        fetchRedirect,
  input logic        flush,
  input logic        linkWrEn,
  input logic [31:0] linkWrData,
  input logic        busy
);

  // R2
  a_r2_one_flush: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush);

  // R3
  a_r3_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (brIssue && !condPass && !busy) |-> (!fetchRedirect && !flush));
  a_r3_not_taken_idle: assert property (@(posedge clk) disable iff (!rstN)
    (brIssue && !condPass && !busy) |=> !busy);

  // R4
  a_r4_link_first: assert property (@(posedge clk) disable iff (!rstN)
    (fetchRedirect && instr[24]) |=> (linkWrEn && linkWrData == $past(pcValue)));

  // R5
  a_r5_link_adjust: assert property (@(posedge clk) disable iff (!rstN)
    (linkWrEn && $past(linkWrEn)) |-> (linkWrData == $past(linkWrData) - 32'd4));

  // R6
  a_r6_no_link: assert property (@(posedge clk) disable iff (!rstN)
    (fetchRedirect && !instr[24]) |=> !linkWrEn ##1 !linkWrEn);

  // R7
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    fetchRedirect |=> busy ##1 busy ##1 !busy);
  a_r7_ignore: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!fetchRedirect && !flush));

  // R8
  a_r8_reset: assert property (@(posedge clk)
    !rstN |=> (!busy && !linkWrEn));

endmodule

bind branchLinkSeq branchLinkSeqChk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .brIssue       (brIssue),
  .condPass      (condPass),
  .instr         (instr),
  .pcValue       (pcValue),
  .fetchRedirect (fetchRedirect),
  .flush         (flush),
  .linkWrEn      (linkWrEn),
  .linkWrData    (linkWrData),
  .busy          (busy)
);

// File: tb/tb_branchLinkSeq.sv
module tb_branchLinkSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brIssue = 1'b0;
  logic        condPass = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pcValue = '0;
  logic        fetchRedirect, flush, linkWrEn, busy;
  logic [31:0] fetchAddr, linkWrData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  branchLinkSeq dut (
    .clk           (clk),
    .rstN          (rstN),
    .brIssue       (brIssue),
    .condPass      (condPass),
    .instr         (instr),
    .pcValue       (pcValue),
    .fetchRedirect (fetchRedirect),
    .fetchAddr     (fetchAddr),
    .flush         (flush),
    .linkWrEn      (linkWrEn),
    .linkWrData    (linkWrData),
    .busy          (busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic lnk, input logic [23:0] off);
    return {4'hE, 3'b101, lnk, off};
  endfunction

  // Drive at negedge, sample 1 ns later, before the next posedge.
  task automatic runBranch(input logic [31:0] pc, input logic [23:0] off,
                           input logic lnk, input logic stray);
    logic [31:0] expTgt;
    logic [31:0] ext;
    ext    = {{8{off[23]}}, off};
    expTgt = pc + (ext << 2);
    @(negedge clk);
    brIssue = 1'b1; condPass = 1'b1; pcValue = pc; instr = mkInstr(lnk, off);
    #1;
    check("R1 redirect", 32'(fetchRedirect), 32'd1);
    check("R1 target", fetchAddr, expTgt);
    if (off[23]) check("R9 backward", 32'(fetchAddr < pc || pc < 32'h0100_0000), 32'd1);
    check("R2 flush", 32'(flush), 32'd1);
    @(negedge clk);
    brIssue = stray; condPass = stray; pcValue = pc ^ 32'h55AA_0F0F;
    instr = mkInstr(~lnk, ~off);
    #1;
    check("R2 flush low", 32'(flush), 32'd0);
    check("R7 busy c2", 32'(busy), 32'd1);
    check("R7 ignore", 32'(fetchRedirect), 32'd0);
    if (lnk) begin
      check("R4 wr", 32'(linkWrEn), 32'd1);
      check("R4 data", linkWrData, pc);
    end else check("R6 no wr c2", 32'(linkWrEn), 32'd0);
    @(negedge clk);
    #1;
    check("R7 busy c3", 32'(busy), 32'd1);
    check("R7 ignore c3", 32'(flush), 32'd0);
    if (lnk) begin
      check("R5 wr", 32'(linkWrEn), 32'd1);
      check("R5 data", linkWrData, pc - 32'd4);
    end else check("R6 no wr c3", 32'(linkWrEn), 32'd0);
    @(negedge clk);
    brIssue = 1'b0; condPass = 1'b0;
    #1;
    check("R7 idle", 32'(busy), 32'd0);
    check("R7 no wr", 32'(linkWrEn), 32'd0);
  endtask

  task automatic runNotTaken(input logic [31:0] pc, input logic [23:0] off, input logic lnk);
    @(negedge clk);
    brIssue = 1'b1; condPass = 1'b0; pcValue = pc; instr = mkInstr(lnk, off);
    #1;
    check("R3 no redirect", 32'(fetchRedirect), 32'd0);
    check("R3 no flush", 32'(flush), 32'd0);
    check("R3 no wr", 32'(linkWrEn), 32'd0);
    @(negedge clk);
    brIssue = 1'b0;
    #1;
    check("R3 idle", 32'(busy), 32'd0);
    check("R3 no wr after", 32'(linkWrEn), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] offs [6];
    logic [31:0] pcs [3];
    offs[0] = 24'h000000; offs[1] = 24'h000001; offs[2] = 24'hFFFFFF;
    offs[3] = 24'h7FFFFF; offs[4] = 24'h800000; offs[5] = 24'hFFF000;
    pcs[0] = 32'h0000_1008; pcs[1] = 32'h8000_0008; pcs[2] = 32'hFFFF_FFF8;

    repeat (3) @(negedge clk);
    #1;
    check("R8 busy", 32'(busy), 32'd0);
    check("R8 redirect", 32'(fetchRedirect), 32'd0);
    check("R8 flush", 32'(flush), 32'd0);
    check("R8 wr", 32'(linkWrEn), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R8 after busy", 32'(busy), 32'd0);

    for (int p = 0; p < 3; p++)
      for (int o = 0; o < 6; o++)
        for (int l = 0; l < 2; l++)
          runBranch(pcs[p], offs[o], l[0], (o % 2) == 1);

    for (int o = 0; o < 6; o++) runNotTaken(pcs[o % 3], offs[o], o[0]);

    // back-to-back: taken branch right after a not-taken one
    runNotTaken(32'h0000_2000, 24'h000010, 1'b1);
    runBranch(32'h0000_2004, 24'hFFFFFE, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule